// File: doc/BRIEF.md
# Transfer Request Arbiter with Per-Stream Line Selection

This block decides which of a bank of transfer streams is served next by a shared transfer engine. Each stream watches exactly one peripheral request line, chosen by its own line-select field. Each stream also carries a 2-bit priority level and an enable bit. When the block is idle and at least one enabled stream sees its request line high, it registers a grant for the stream with the highest level. Ties go to the lowest stream number. The grant is held until the engine ends the transfer with a one-cycle done pulse.

The block also runs a four-phase handshake with the peripheral. When the engine signals that it is accessing the peripheral for the granted stream, an acknowledge rises on the request line that stream selects. That acknowledge stays high until the peripheral drops its request. A stream whose acknowledge is still high cannot be granted again, so a slow peripheral cannot be served twice for one request.

Top module: `dreq_arbiter`

## Requirements
- R1: During and directly after reset, grant_valid is 0 and every bit of periph_ack is 0.
- R2: Stream s responds only to request line chan_sel[3s+2:3s]. A request on any other line never makes stream s eligible.
- R3: Among eligible streams, the stream with the numerically highest prio_lvl[2s+1:2s] is granted. Level 3 is the most urgent and 0 the least.
- R4: When eligible streams share the highest level, the lowest-numbered one is granted.
- R5: A stream with stream_en[s] = 0 is never granted, whatever its request line does.
- R6: With grant_valid low and at least one stream eligible at a clock edge, grant_valid is 1 after that edge and grant_idx names the winner. While grant_valid is 1, grant_idx and grant_valid do not change until engine_done is sampled high; grant_valid is 0 after that edge.
- R7: engine_access sampled high while grant_valid is 1 raises periph_ack on the line selected by the granted stream, from the next cycle.
- R8: Once raised, a stream's acknowledge stays high while its selected request line is high. It falls in the cycle after that line is sampled low.
- R9: A stream whose acknowledge is still high is not eligible for a new grant.
- R10: engine_done and engine_access have no effect while grant_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_en | input | 8 | Per-stream enable |
| chan_sel | input | 24 | Per-stream request line select, 3 bits per stream, stream s at [3s+2:3s] |
| prio_lvl | input | 16 | Per-stream priority level, 2 bits per stream, stream s at [2s+1:2s] |
| periph_req | input | 8 | Peripheral request lines |
| engine_access | input | 1 | Engine is accessing the peripheral of the granted stream |
| engine_done | input | 1 | One-cycle pulse ending the granted transfer |
| periph_ack | output | 8 | Acknowledge back to each request line |
| grant_valid | output | 1 | A grant is held |
| grant_idx | output | 3 | Index of the granted stream |

## Verification
The hardest situation to reach is a stream that has been served and released by the engine while its peripheral still holds the request. Here the stream has to be skipped even though it would win on level and index. The bench reaches it with a directed sequence. It grants a high-level stream, closes the transfer with access and done, and keeps that stream's request high. It then checks that a lower-ranked stream is granted next and that both acknowledges are up together. A sweep over a few hundred arithmetic patterns of enables, line selects, levels and requests then compares every grant with a winner computed in the bench.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   localparam int PRIO_W = 2;
   typedef enum logic [PRIO_W-1:0] {
      PRIO_LOW       = 2'd0,
      PRIO_MEDIUM    = 2'd1,
      PRIO_HIGH      = 2'd2,
      PRIO_VERY_HIGH = 2'd3
   } prio_e;
endpackage

// File: rtl/dreq_route.sv
// Per-stream request line multiplexer.
module dreq_route #(
   parameter int N_STREAMS = 8,
   parameter int N_LINES   = 8,
   parameter int SEL_W     = 3
) (
   input  logic [N_STREAMS*SEL_W-1:0] chan_sel,
   input  logic [N_LINES-1:0]         periph_req,
   output logic [N_STREAMS-1:0]       req_seen
);
   for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
      logic [SEL_W-1:0] sel;
      assign sel = chan_sel[s*SEL_W +: SEL_W];
      if (N_LINES == (1 << SEL_W)) begin : g_full
         assign req_seen[s] = periph_req[sel];
      end else begin : g_guard
         // Select codes past the last line see no request.
         assign req_seen[s] = (int'(sel) < N_LINES) ? periph_req[sel] : 1'b0;
      end
   end
endmodule

// File: rtl/dreq_pick.sv
// Highest level wins; lower index wins ties.
module dreq_pick import dreq_pkg::*; #(
   parameter int N_STREAMS = 8,
   parameter int IDX_W     = 3
) (
   input  logic [N_STREAMS-1:0]        elig,
   input  logic [N_STREAMS*PRIO_W-1:0] prio_lvl,
   output logic                        any,
   output logic [IDX_W-1:0]            win_idx
);
   logic [PRIO_W-1:0] best;
   always_comb begin
      any     = 1'b0;
      best    = '0;
      win_idx = '0;
      for (int s = 0; s < N_STREAMS; s++) begin
         if (elig[s] && (!any || prio_lvl[s*PRIO_W +: PRIO_W] > best)) begin
            any     = 1'b1;
            best    = prio_lvl[s*PRIO_W +: PRIO_W];
            win_idx = IDX_W'(s);
         end
      end
   end
endmodule

// File: rtl/dreq_ack.sv
// Four-phase acknowledge state per stream, folded onto request lines.
module dreq_ack #(
   parameter int N_STREAMS = 8,
   parameter int N_LINES   = 8,
   parameter int SEL_W     = 3,
   parameter int IDX_W     = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       grant_valid,
   input  logic [IDX_W-1:0]           grant_idx,
   input  logic                       engine_access,
   input  logic [N_STREAMS-1:0]       req_seen,
   input  logic [N_STREAMS*SEL_W-1:0] chan_sel,
   output logic [N_STREAMS-1:0]       ack_q,
   output logic [N_LINES-1:0]         periph_ack
);
   for (genvar s = 0; s < N_STREAMS; s++) begin : g_flag
      logic set_now;
      assign set_now = grant_valid && engine_access && (int'(grant_idx) == s);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           ack_q[s] <= 1'b0;
         else if (set_now)     ack_q[s] <= 1'b1;
         else if (!req_seen[s]) ack_q[s] <= 1'b0;
      end
   end

   always_comb begin
      periph_ack = '0;
      for (int s = 0; s < N_STREAMS; s++) begin
         if (ack_q[s] && int'(chan_sel[s*SEL_W +: SEL_W]) < N_LINES)
            periph_ack[chan_sel[s*SEL_W +: SEL_W]] = 1'b1;
      end
   end
endmodule

// File: rtl/dreq_arbiter.sv
module dreq_arbiter import dreq_pkg::*; #(
   parameter int N_STREAMS = 8,
   parameter int N_LINES   = 8,
   localparam int SEL_W    = (N_LINES > 1) ? $clog2(N_LINES) : 1,
   localparam int IDX_W    = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_STREAMS-1:0]        stream_en,
   input  logic [N_STREAMS*SEL_W-1:0]  chan_sel,
   input  logic [N_STREAMS*PRIO_W-1:0] prio_lvl,
   input  logic [N_LINES-1:0]          periph_req,
   input  logic                        engine_access,
   input  logic                        engine_done,
   output logic [N_LINES-1:0]          periph_ack,
   output logic                        grant_valid,
   output logic [IDX_W-1:0]            grant_idx
);
   if (N_STREAMS < 2) begin : g_bad_streams
      $error("dreq_arbiter: N_STREAMS must be at least 2");
   end
   if (N_LINES < 2) begin : g_bad_lines
      $error("dreq_arbiter: N_LINES must be at least 2");
   end

   logic [N_STREAMS-1:0] req_seen;
   logic [N_STREAMS-1:0] ack_q;
   logic [N_STREAMS-1:0] elig;
   logic                 any;
   logic [IDX_W-1:0]     win_idx;

   dreq_route #(.N_STREAMS(N_STREAMS), .N_LINES(N_LINES), .SEL_W(SEL_W)) route_i (
      .chan_sel   (chan_sel),
      .periph_req (periph_req),
      .req_seen   (req_seen)
   );

   assign elig = stream_en & req_seen & ~ack_q;

   dreq_pick #(.N_STREAMS(N_STREAMS), .IDX_W(IDX_W)) pick_i (
      .elig     (elig),
      .prio_lvl (prio_lvl),
      .any      (any),
      .win_idx  (win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_idx   <= '0;
      end else if (grant_valid) begin
         if (engine_done) grant_valid <= 1'b0;
      end else if (any) begin
         grant_valid <= 1'b1;
         grant_idx   <= win_idx;
      end
   end

   dreq_ack #(.N_STREAMS(N_STREAMS), .N_LINES(N_LINES), .SEL_W(SEL_W), .IDX_W(IDX_W)) ack_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .grant_valid   (grant_valid),
      .grant_idx     (grant_idx),
      .engine_access (engine_access),
      .req_seen      (req_seen),
      .chan_sel      (chan_sel),
      .ack_q         (ack_q),
      .periph_ack    (periph_ack)
   );
endmodule

// File: rtl/dreq_arbiter_chk.sv
module dreq_arbiter_chk #(
   parameter int N_STREAMS = 8,
   parameter int IDX_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 grant_valid,
   input logic [IDX_W-1:0]     grant_idx,
   input logic                 engine_done,
   input logic                 engine_access,
   input logic [N_STREAMS-1:0] stream_en,
   input logic [N_STREAMS-1:0] ack_q,
   input logic [N_STREAMS-1:0] req_seen
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!grant_valid && ack_q == '0));

   assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid && !engine_done |=> grant_valid && $stable(grant_idx));

   assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid && engine_done |=> !grant_valid);

   assert_grant_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_valid) |-> ((($past(stream_en) >> grant_idx) & 1) != 0));

   assert_grant_not_acked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_valid) |-> ((($past(ack_q) >> grant_idx) & 1) == 0));

   for (genvar s = 0; s < N_STREAMS; s++) begin : g_s
      assert_ack_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ack_q[s]) |-> $past(grant_valid && engine_access && int'(grant_idx) == s));
      assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ack_q[s] && req_seen[s] |=> ack_q[s]);
   end
endmodule

bind dreq_arbiter dreq_arbiter_chk #(.N_STREAMS(N_STREAMS), .IDX_W(IDX_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .grant_valid   (grant_valid),
   .grant_idx     (grant_idx),
   .engine_done   (engine_done),
   .engine_access (engine_access),
   .stream_en     (stream_en),
   .ack_q         (ack_q),
   .req_seen      (req_seen)
);

// File: tb/dreq_arbiter_tb_top.sv
`timescale 1ns/1ps
module dreq_arbiter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  stream_en = '0;
   logic [23:0] chan_sel = '0;
   logic [15:0] prio_lvl = '0;
   logic [7:0]  periph_req = '0;
   logic        engine_access = 1'b0;
   logic        engine_done = 1'b0;
   logic [7:0]  periph_ack;
   logic        grant_valid;
   logic [2:0]  grant_idx;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dreq_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .chan_sel(chan_sel),
      .prio_lvl(prio_lvl), .periph_req(periph_req), .engine_access(engine_access),
      .engine_done(engine_done), .periph_ack(periph_ack), .grant_valid(grant_valid),
      .grant_idx(grant_idx)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   // Expected winner, or -1 when no stream is eligible (no acks pending).
   function automatic int winner(logic [7:0] en, logic [7:0] req,
                                 logic [23:0] sel, logic [15:0] pr);
      int w = -1;
      int best = -1;
      for (int s = 0; s < 8; s++) begin
         int line = int'(sel[s*3 +: 3]);
         int lv = int'(pr[s*2 +: 2]);
         if (en[s] && req[line] && lv > best) begin
            best = lv;
            w = s;
         end
      end
      return w;
   endfunction

   // Run one transfer on the held grant, then drop all requests.
   task automatic close_transfer(int w, string tag);
      engine_access = 1'b1;
      nxt();
      engine_access = 1'b0;
      chk(periph_ack == 8'(1 << chan_sel[w*3 +: 3]), {tag, " R7 ack line"},
          int'(periph_ack), 1 << chan_sel[w*3 +: 3]);
      engine_done = 1'b1;
      nxt();
      engine_done = 1'b0;
      chk(!grant_valid, {tag, " R6 release"}, int'(grant_valid), 0);
      periph_req = '0;
      nxt();
      chk(periph_ack == 0, {tag, " R8 ack drop"}, int'(periph_ack), 0);
      chk(!grant_valid, {tag, " R6 idle"}, int'(grant_valid), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) nxt();
      chk(!grant_valid && periph_ack == 0, "R1 reset state",
          int'({grant_valid, periph_ack}), 0);
      rst_n = 1'b1;
      nxt();
      chk(!grant_valid, "R1 after reset", int'(grant_valid), 0);

      // R2: stream 4 selects line 3; every other line is active.
      stream_en = 8'h10;
      chan_sel[12 +: 3] = 3'd3;
      periph_req = 8'hF7;
      nxt(); nxt();
      chk(!grant_valid, "R2 foreign lines ignored", int'(grant_valid), 0);
      periph_req = 8'h08;
      nxt();
      chk(grant_valid && grant_idx == 3'd4, "R2 own line grants",
          int'(grant_idx), 4);
      close_transfer(4, "R2");

      // R5 and R10: all disabled, stray done/access pulses.
      stream_en = '0;
      periph_req = 8'hFF;
      engine_access = 1'b1;
      engine_done = 1'b1;
      nxt(); nxt();
      chk(!grant_valid, "R5 disabled never granted", int'(grant_valid), 0);
      chk(periph_ack == 0, "R10 access without grant", int'(periph_ack), 0);
      engine_access = 1'b0;
      engine_done = 1'b0;
      periph_req = '0;
      nxt();

      // R3 R4 R6 R8 R9 directed: stream 2 (line 1, level 3), stream 5 (line 6, level 1).
      stream_en = 8'h24;
      chan_sel = '0;
      chan_sel[6 +: 3] = 3'd1;
      chan_sel[15 +: 3] = 3'd6;
      prio_lvl = '0;
      prio_lvl[4 +: 2] = dreq_pkg::PRIO_VERY_HIGH;
      prio_lvl[10 +: 2] = dreq_pkg::PRIO_MEDIUM;
      periph_req = 8'h42;
      nxt();
      chk(grant_valid && grant_idx == 3'd2, "R3 level 3 wins", int'(grant_idx), 2);
      prio_lvl[10 +: 2] = dreq_pkg::PRIO_VERY_HIGH;
      periph_req = 8'h40;
      nxt(); nxt();
      chk(grant_valid && grant_idx == 3'd2, "R6 grant held", int'(grant_idx), 2);
      periph_req = 8'h42;
      engine_access = 1'b1;
      nxt();
      engine_access = 1'b0;
      chk(periph_ack == 8'h02, "R7 ack stream 2", int'(periph_ack), 2);
      engine_done = 1'b1;
      nxt();
      engine_done = 1'b0;
      chk(!grant_valid, "R6 done releases", int'(grant_valid), 0);
      nxt();
      chk(grant_valid && grant_idx == 3'd5, "R9 acked stream skipped",
          int'(grant_idx), 5);
      chk(periph_ack == 8'h02, "R8 ack held while request high", int'(periph_ack), 2);
      engine_access = 1'b1;
      nxt();
      engine_access = 1'b0;
      engine_done = 1'b1;
      chk(periph_ack == 8'h42, "R7 two acks", int'(periph_ack), 8'h42);
      nxt();
      engine_done = 1'b0;
      periph_req = 8'h40;
      nxt();
      chk(periph_ack == 8'h40, "R8 only released line drops", int'(periph_ack), 8'h40);
      chk(!grant_valid, "R9 no regrant while acked", int'(grant_valid), 0);
      periph_req = '0;
      nxt();
      chk(periph_ack == 0, "R8 second release", int'(periph_ack), 0);

      // Sweep: arithmetic patterns, winner computed in the bench (R2 R3 R4 R5).
      for (int t = 0; t < 256; t++) begin
         logic [7:0]  en_t;
         logic [7:0]  rq_t;
         logic [23:0] sl_t;
         logic [15:0] pr_t;
         int w;
         en_t = 8'((t * 37 + 11) ^ (t >> 3));
         rq_t = 8'(t * 91 + 5 + t * t);
         for (int s = 0; s < 8; s++) begin
            sl_t[s*3 +: 3] = 3'((s * 5 + t + (t >> 3) * s) % 8);
            pr_t[s*2 +: 2] = 2'((t * 7 + s * 3 + (t >> 2) * s) % 4);
         end
         if (t % 16 == 3) pr_t = 16'hFFFF;
         if (t % 16 == 9) pr_t = 16'h0000;
         stream_en = en_t;
         chan_sel = sl_t;
         prio_lvl = pr_t;
         periph_req = rq_t;
         w = winner(en_t, rq_t, sl_t, pr_t);
         nxt();
         if (w < 0) begin
            chk(!grant_valid, "R5 sweep no eligible", int'(grant_valid), 0);
            periph_req = '0;
            nxt();
         end else begin
            chk(grant_valid && int'(grant_idx) == w, "R3 R4 sweep winner",
                int'(grant_idx), w);
            close_transfer(w, "sweep");
         end
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule